// File: doc/BRIEF.md
# Johnson-Coded Decade Counter

This block counts events in tens. Its state is held in a five-stage twisted-ring register, which has ten legal states. Each state drives exactly one of ten decoded outputs high. A carry output is high for the first half of the cycle and low for the second half, so it gives a square wave at one tenth of the event rate. A rising carry can drive the count clock of a following stage, so stages can be chained into a multi-digit counter.

A count event comes from one of two sources. The first is a rising edge on the count clock while the inhibit input is low. The second is a falling edge on the inhibit input while the count clock is high. Both inputs are asynchronous to the system clock. Each passes through a synchronizer and is edge-detected on the free-running system clock. A master reset, asynchronous on assertion and released in step with the system clock, returns the counter to position zero. The reset takes priority over every other input.

Top module: `jdc_decade_top`

## Requirements
- R1: While the master reset is high, decoded output 0 (decOut bit 0) is high, bits 1 to 9 are low and carryOut is high. Toggling the count clock or the inhibit input during reset does not change this, and position 0 is still shown after the reset is released.
- R2: Exactly one bit of decOut is high in every cycle. Bit k high means the counter is at position k.
- R3: A rising edge on countClk while countInhibit is low moves the high bit from position k to position (k+1) mod 10.
- R4: While countInhibit is high, rising and falling edges on countClk leave decOut unchanged.
- R5: A falling edge on countInhibit while countClk is high advances the position by one.
- R6: A rising edge on countInhibit, a falling edge on countClk, or a falling edge on countInhibit while countClk is low leaves decOut unchanged.
- R7: A countClk rise and a countInhibit fall that arrive in the same sampling cycle advance the position once, not twice.
- R8: carryOut is high at positions 0 to 4 and low at positions 5 to 9. It rises only on the step from position 9 to position 0.
- R9: A qualifying input edge that is set up before a system clock edge shows on decOut after the third rising sysClk edge. The output still shows the old position after the second edge.
- R10: When carryOut of one stage drives countClk of a second stage whose countInhibit is low, the second stage advances once for every ten advances of the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sysClk | input | 1 | Free-running system clock that samples the inputs |
| masterReset | input | 1 | Active-high reset: asserts asynchronously, released in step with sysClk |
| countClk | input | 1 | Count clock, asynchronous to sysClk |
| countInhibit | input | 1 | Active-high inhibit; its falling edge also counts while countClk is high |
| decOut | output | 10 | One-hot decoded position; bit k is high at position k |
| carryOut | output | 1 | High at positions 0 to 4, low at positions 5 to 9 |

## Verification
The bench builds two instances with the default five stages and a two-flop synchronizer depth. The second instance is clocked by the first one's carry, so every random run also checks a two-digit cascade against a modulo-100 reference. The default depth gives the exact three-edge latency that the directed R9 check measures. Five stages give a ten-state cycle, which random runs wrap many times, so the carry's five-high/five-low pattern and its rise on wrap-around are checked often.

// File: rtl/jdc_pkg.sv
package jdc_pkg;

  // Count strobes sent from control to the ring register
  typedef struct packed {
    logic byClock;   // qualified count clock rise
    logic byEnable;  // qualified inhibit fall with clock high
  } jdc_strobe_t;

endpackage

// File: rtl/jdc_sync.sv
module jdc_sync #(
  parameter int WIDTH = 2,
  parameter int DEPTH = 2
) (
  input  logic             sysClk,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [DEPTH];

  // Data-only chain: no reset, so it keeps following its inputs during reset
  always_ff @(posedge sysClk) begin
    stageQ[0] <= asyncIn;
    for (int i = 1; i < DEPTH; i++) begin
      stageQ[i] <= stageQ[i-1];
    end
  end

  assign syncOut = stageQ[DEPTH-1];

endmodule

// File: rtl/jdc_rst_sync.sv
module jdc_rst_sync #(
  parameter int DEPTH = 2
) (
  input  logic sysClk,
  input  logic rstAsync,
  output logic rstN
);

  logic [DEPTH-1:0] rstChain;

  always_ff @(posedge sysClk or posedge rstAsync) begin
    if (rstAsync) rstChain <= '0;
    else          rstChain <= {rstChain[DEPTH-2:0], 1'b1};
  end

  assign rstN = rstChain[DEPTH-1];

endmodule

// File: rtl/jdc_ctrl.sv
module jdc_ctrl
  import jdc_pkg::*;
(
  input  logic        sysClk,
  input  logic        rstN,
  input  logic        clkS,
  input  logic        enS,
  output jdc_strobe_t strobe
);

  logic clkD;
  logic enD;

  // Previous samples for edge detection; these follow the inputs even in reset
  always_ff @(posedge sysClk) begin
    clkD <= clkS;
    enD  <= enS;
  end

  logic clkRise;
  logic enFall;

  always_comb begin
    clkRise = clkS & ~clkD;
    enFall  = enD & ~enS;
    strobe.byClock  = clkRise & ~enS;
    strobe.byEnable = enFall & clkS;
  end

  // R4
  inhibit_blocks_clock_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    (enS && $past(enS)) |-> !(strobe.byClock || strobe.byEnable));

  // R6
  clock_low_no_count_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    !clkS |-> !(strobe.byClock || strobe.byEnable));

endmodule

// File: rtl/jdc_ring.sv
module jdc_ring
  import jdc_pkg::*;
#(
  parameter  int STAGES = 5,
  localparam int OUTS   = 2 * STAGES,
  localparam int HALF   = STAGES
) (
  input  logic            sysClk,
  input  logic            rstN,
  input  jdc_strobe_t     strobe,
  output logic [OUTS-1:0] decOut,
  output logic            carryOut
);

  logic [STAGES-1:0] ringQ;
  logic [STAGES-1:0] nextQ;
  logic              advance;
  logic              legal;

  // A coincident pair of strobes still gives only one step
  assign advance = strobe.byClock | strobe.byEnable;

  // A legal twisted-ring code has at most one change between adjacent bits
  always_comb begin
    int unsigned diffs;
    diffs = 0;
    for (int i = 0; i < STAGES - 1; i++) begin
      diffs = diffs + 32'(ringQ[i] ^ ringQ[i+1]);
    end
    legal = (diffs <= 1);
  end

  // Illegal codes go back to all-zero on the next step
  assign nextQ = legal ? {ringQ[STAGES-2:0], ~ringQ[STAGES-1]} : '0;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN)        ringQ <= '0;
    else if (advance) ringQ <= nextQ;
  end

  // Each decoded position is a test on two adjacent bits
  for (genvar k = 0; k < OUTS; k++) begin : g_dec
    if (k == 0) begin : g_zero
      assign decOut[k] = ~ringQ[STAGES-1] & ~ringQ[0];
    end else if (k < STAGES) begin : g_fill
      assign decOut[k] = ringQ[k-1] & ~ringQ[k];
    end else if (k == STAGES) begin : g_full
      assign decOut[k] = ringQ[STAGES-1] & ringQ[0];
    end else begin : g_drain
      assign decOut[k] = ~ringQ[k-STAGES-1] & ringQ[k-STAGES];
    end
  end

  assign carryOut = ~ringQ[STAGES-1];

  // R2
  one_hot_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    $countones(decOut) == 1);

  // R3
  step_rotates_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    (advance && rstN) |=> decOut == {$past(decOut[OUTS-2:0]), $past(decOut[OUTS-1])});

  // R6
  idle_holds_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    !advance |=> $stable(decOut));

  // R8
  carry_half_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    carryOut == (|decOut[HALF-1:0]));

  // R8
  carry_rise_wrap_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    $rose(carryOut) |-> $past(decOut[OUTS-1]));

endmodule

// File: rtl/jdc_decade_top.sv
module jdc_decade_top
  import jdc_pkg::*;
#(
  parameter  int STAGES     = 5,
  parameter  int SYNC_DEPTH = 2,
  parameter  int RST_DEPTH  = 2,
  localparam int OUTS       = 2 * STAGES
) (
  input  logic            sysClk,
  input  logic            masterReset,
  input  logic            countClk,
  input  logic            countInhibit,
  output logic [OUTS-1:0] decOut,
  output logic            carryOut
);

  logic        rstN;
  logic [1:0]  syncBus;
  jdc_strobe_t strobe;

  jdc_rst_sync #(.DEPTH(RST_DEPTH)) u_rst (
    .sysClk  (sysClk),
    .rstAsync(masterReset),
    .rstN    (rstN)
  );

  jdc_sync #(.WIDTH(2), .DEPTH(SYNC_DEPTH)) u_sync (
    .sysClk (sysClk),
    .asyncIn({countInhibit, countClk}),
    .syncOut(syncBus)
  );

  jdc_ctrl u_ctrl (
    .sysClk(sysClk),
    .rstN  (rstN),
    .clkS  (syncBus[0]),
    .enS   (syncBus[1]),
    .strobe(strobe)
  );

  jdc_ring #(.STAGES(STAGES)) u_ring (
    .sysClk  (sysClk),
    .rstN    (rstN),
    .strobe  (strobe),
    .decOut  (decOut),
    .carryOut(carryOut)
  );

  // R1
  reset_zero_chk: assert property (@(posedge sysClk)
    masterReset |-> (decOut == OUTS'(1) && carryOut));

endmodule

// File: tb/jdc_decade_top_tb.sv
`timescale 1ns/1ps
module jdc_decade_top_tb;

  logic       sysClk = 1'b0;
  logic       masterReset = 1'b1;
  logic       countClk = 1'b0;
  logic       countInhibit = 1'b0;
  logic [9:0] decOut;
  logic       carryOut;
  logic [9:0] hiDec;
  logic       hiCarry;

  always #2.5 sysClk = ~sysClk;

  jdc_decade_top u_dut (
    .sysClk(sysClk), .masterReset(masterReset), .countClk(countClk),
    .countInhibit(countInhibit), .decOut(decOut), .carryOut(carryOut)
  );

  // Second digit of the cascade, clocked by the first digit's carry
  jdc_decade_top u_dut_hi (
    .sysClk(sysClk), .masterReset(masterReset), .countClk(carryOut),
    .countInhibit(1'b0), .decOut(hiDec), .carryOut(hiCarry)
  );

  int  compared = 0;
  int  mismatched = 0;
  int  pos = 0;
  int  hiPos = 0;
  bit  mClk = 0;
  bit  mEn = 0;
  bit  inReset = 1;
  bit  done = 0;

  function automatic logic [9:0] hotOf(int p);
    return 10'(1) << p;
  endfunction

  task automatic compare(string req);
    compared++;
    if (decOut !== hotOf(pos) || carryOut !== (pos < 5)) begin
      mismatched++;
      $display("FAIL %s: decOut=%b carry=%b exp decOut=%b carry=%b",
               req, decOut, carryOut, hotOf(pos), (pos < 5));
    end
  endtask

  task automatic compareHi(string req);
    compared++;
    if (hiDec !== hotOf(hiPos) || hiCarry !== (hiPos < 5)) begin
      mismatched++;
      $display("FAIL %s: hiDec=%b carry=%b exp hiDec=%b carry=%b",
               req, hiDec, hiCarry, hotOf(hiPos), (hiPos < 5));
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge sysClk);
    @(negedge sysClk);
  endtask

  // Reference step rule, evaluated at the port level
  task automatic drive(bit c, bit e);
    bit stepIt;
    countClk = c;
    countInhibit = e;
    stepIt = (c && !mClk && !e) || (!e && mEn && c);
    if (stepIt && !inReset) begin
      if (pos == 9) hiPos = (hiPos + 1) % 10;
      pos = (pos + 1) % 10;
    end
    mClk = c;
    mEn = e;
  endtask

  task automatic apply(bit c, bit e, string req);
    drive(c, e);
    settle(5);
    compare(req);
  endtask

  task automatic doReset();
    masterReset = 1'b1;
    inReset = 1;
    pos = 0;
    hiPos = 0;
    settle(2);
    compare("R1");
    // Activity during reset must not move the counter
    drive(!mClk, mEn);
    settle(2);
    compare("R1");
    drive(!mClk, mEn);
    settle(5);
    masterReset = 1'b0;
    inReset = 0;
    settle(5);
    compare("R1");
    compareHi("R1");
  endtask

  initial begin
    settle(1);
    doReset();

    // R9: exact latency of a clock rise
    @(negedge sysClk);
    drive(1, 0);
    repeat (2) @(posedge sysClk);
    @(negedge sysClk);
    compared++;
    if (decOut !== hotOf(0)) begin
      mismatched++;
      $display("FAIL R9: early decOut=%b exp=%b", decOut, hotOf(0));
    end
    @(posedge sysClk);
    @(negedge sysClk);
    compare("R9");
    settle(3);

    // R3 and R8: run through a full wrap
    for (int i = 0; i < 12; i++) begin
      apply(0, 0, "R6");
      apply(1, 0, "R3");
      if (pos == 0) compare("R8");
    end
    compareHi("R10");

    // R4: clock edges ignored while inhibited
    apply(1, 1, "R6");
    apply(0, 1, "R4");
    apply(1, 1, "R4");
    apply(0, 1, "R4");
    // R5 and R6: enable as a second clock
    apply(1, 1, "R4");
    apply(1, 0, "R5");
    apply(1, 1, "R6");
    apply(0, 1, "R6");
    apply(0, 0, "R6");
    // R7: both qualifying edges in the same cycle
    apply(0, 1, "R6");
    apply(1, 0, "R7");

    void'($urandom(32'd4017));
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom % 5);
      case (op)
        0: apply(!mClk, mEn, "R3");
        1: apply(mClk, !mEn, "R5");
        2: apply(!mClk, !mEn, "R7");
        3: apply(!mClk, mEn, "R4");
        default: apply(1'($urandom), 1'($urandom), "R2");
      endcase
      if (n % 50 == 49) compareHi("R10");
      if (n % 200 == 199) doReset();
    end
    compareHi("R10");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule